// File: doc/BRIEF.md
# Triangular spread-spectrum fraction sequencer

This block spreads the output frequency of a fractional-N PLL over a band by rewriting the PLL's fractional divider from a triangular profile. A periodic trigger, normally produced by a timer, paces the modulation. The block watches both edges of this trigger. A rising edge requests the next fraction word. A falling edge requests a pair of configuration-register words: the first clears the fractional-enable bit and the second sets it again.

The block orders the three writes so that every fraction update happens while the fractional-enable bit is cleared. It sends the clear word, then the new fraction word, then the set word. When the set word is issued, the table index has already moved on to the next entry. The 32-entry profile is computed from the index and is never stored. Each write appears on a one-cycle strobe, together with a target select and a 32-bit data word.

Dropping the run input finishes any half-done update, so the PLL is left with its fractional mode enabled. It also returns the profile to its first entry. If a trigger edge arrives before the previous request has been serviced, that edge is counted as an overrun and dropped.

Top module: `sscg_frac_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `wr_stb` and `overrun` are both 0.
- R2: The profile entry for index k (0..31) is computed as follows. Entry 0 is 0. For k = 1 to 16 the entry is k*0x200-1, so entry 16 is the peak 0x1FFF. For k = 17 to 31 the entry is (32-k)*0x200-1, which runs from 0x1DFF down to 0x01FF. After entry 31 the index wraps to 0.
- R3: A fraction write has `wr_sel`=0. Its `wr_data` holds the 13-bit profile entry in bits 15:3, and every other bit is 0.
- R4: Each accepted rising edge of the trigger yields exactly one fraction write. The index advances by one after each fraction write.
- R5: Each accepted falling edge yields two configuration writes (`wr_sel`=1): the clear word first and the set word second. A pending fraction write is issued between them. While run is high, the set word waits until that fraction write has been issued.
- R6: A fraction request that arrives while the enable bit has not been cleared is held. It is issued only after the clear word of the next falling edge.
- R7: The trigger is synchronized before its edges are detected. A new rising edge that arrives while a fraction request is pending or not yet closed by a set word is dropped. A new falling edge that arrives while the previous pair is unfinished is also dropped. Either drop sets `overrun`, which stays set until reset.
- R8: While run is low, trigger edges are ignored. A clear word that has already been issued is followed by its pending fraction write (if any) and then by the set word. Once the block is idle, the index returns to 0.
- R9: The clear word is 0x00000300 and the set word is 0x00000310. The fractional-enable bit is bit 4 of the configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Modulation run control |
| trig_in | input | 1 | Asynchronous pacing trigger from a timer |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_sel | output | 1 | Write target: 0 fraction register, 1 configuration register |
| wr_data | output | 32 | Write data word |
| overrun | output | 1 | Sticky flag for a dropped trigger edge |

## Verification
The hardest state to reach from the ports is a drop. A trigger edge must land while the previous clear, fraction and set sequence is still in flight, and that sequence lasts only a few cycles after synchronization. The bench reaches it with one-cycle trigger pulses: a rise, a fall and a second rise, each one cycle apart. The second rise then meets a still-pending fraction request, and the following fall meets an enable bit that is still cleared. A second hard case is a falling edge that comes first and leaves the enable bit cleared with no fraction pending. The bench starts the trigger high with run low, raises run, lowers the trigger, and then shows that dropping run issues the set word.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_FRAC = 2'd2,
    ACT_SET  = 2'd3
  } wr_act_e;

  localparam logic SEL_FRAC = 1'b0;
  localparam logic SEL_CFG  = 1'b1;

  // distance of an index from the start of the triangle
  function automatic int unsigned tri_fold(input int unsigned idx,
                                           input int unsigned depth);
    if (idx <= depth / 2) return idx;
    return depth - idx;
  endfunction

  // level for a folded distance: zero at the origin, else fold*step-1
  function automatic int unsigned tri_level(input int unsigned fold,
                                            input int unsigned step);
    if (fold == 0) return 0;
    return fold * step - 1;
  endfunction

endpackage

// File: rtl/sscg_edge_sync.sv
module sscg_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic             sync_now;
  logic             sync_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], async_in};
  end

  assign sync_now  = chain_q[CHAIN-2];
  assign sync_prev = chain_q[CHAIN-1];
  assign rise      = sync_now & ~sync_prev;
  assign fall      = ~sync_now & sync_prev;

endmodule

// File: rtl/sscg_tri_table.sv
module sscg_tri_table import sscg_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int STEP  = 32'h200,
  parameter int VAL_W = 13,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [VAL_W-1:0] level
);
  int unsigned fold_c;

  always_comb begin
    fold_c = tri_fold(int'(idx), DEPTH);
    level  = VAL_W'(tri_level(fold_c, STEP));
  end

endmodule

// File: rtl/sscg_wr_sched.sv
module sscg_wr_sched import sscg_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             rise,
  input  logic             fall,
  output wr_act_e          act,
  output logic [IDX_W-1:0] idx,
  output logic             overrun
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic frac_req;
  logic clr_req;
  logic en_clr;
  logic frac_done;

  logic rise_ok, rise_drop, fall_ok, fall_drop, idle_c;

  always_comb begin
    act = ACT_NONE;
    if (clr_req && !en_clr)
      act = ACT_CLR;
    else if (en_clr && frac_req && !frac_done)
      act = ACT_FRAC;
    else if (en_clr && (frac_done || (!run_en && !frac_req)))
      act = ACT_SET;
  end

  assign rise_ok   = run_en && rise && !frac_req && !frac_done;
  assign rise_drop = run_en && rise && (frac_req || frac_done);
  assign fall_ok   = run_en && fall && !clr_req && !en_clr;
  assign fall_drop = run_en && fall && (clr_req || en_clr);
  assign idle_c    = !run_en && !en_clr && !clr_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frac_req  <= 1'b0;
      clr_req   <= 1'b0;
      en_clr    <= 1'b0;
      frac_done <= 1'b0;
      idx       <= '0;
      overrun   <= 1'b0;
    end else begin
      if (rise_ok) frac_req <= 1'b1;
      if (fall_ok) clr_req  <= 1'b1;
      if (rise_drop || fall_drop) overrun <= 1'b1;
      unique case (act)
        ACT_CLR: begin
          clr_req <= 1'b0;
          en_clr  <= 1'b1;
        end
        ACT_FRAC: begin
          frac_req  <= 1'b0;
          frac_done <= 1'b1;
          idx       <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        end
        ACT_SET: begin
          en_clr    <= 1'b0;
          frac_done <= 1'b0;
        end
        default: ;
      endcase
      if (idle_c) begin
        frac_req <= 1'b0;
        idx      <= '0;
      end
    end
  end

  // R7: a dropped edge must leave the flag raised for good
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

// File: rtl/sscg_frac_seq.sv
module sscg_frac_seq import sscg_pkg::*; #(
  parameter int          DEPTH       = 32,
  parameter int          STEP        = 32'h200,
  parameter int          VAL_W       = 13,
  parameter int          FRAC_LSB    = 3,
  parameter int          WORD_W      = 32,
  parameter int          FRACEN_BIT  = 4,
  parameter logic [31:0] CFG_BASE    = 32'h0000_0300,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              trig_in,
  output logic              wr_stb,
  output logic              wr_sel,
  output logic [WORD_W-1:0] wr_data,
  output logic              overrun
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [WORD_W-1:0] EN_MASK  = WORD_W'(1) << FRACEN_BIT;
  localparam logic [WORD_W-1:0] CFG_CLR  = WORD_W'(CFG_BASE) & ~EN_MASK;
  localparam logic [WORD_W-1:0] CFG_SET  = WORD_W'(CFG_BASE) | EN_MASK;
  localparam logic [WORD_W-1:0] FIELD_MK =
    ((WORD_W'(1) << VAL_W) - WORD_W'(1)) << FRAC_LSB;

  logic             trig_rise;
  logic             trig_fall;
  wr_act_e          act;
  logic [IDX_W-1:0] idx;
  logic [VAL_W-1:0] level;

  sscg_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (trig_in),
    .rise     (trig_rise),
    .fall     (trig_fall)
  );

  sscg_wr_sched #(.DEPTH(DEPTH), .IDX_W(IDX_W)) sched_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .rise    (trig_rise),
    .fall    (trig_fall),
    .act     (act),
    .idx     (idx),
    .overrun (overrun)
  );

  sscg_tri_table #(.DEPTH(DEPTH), .STEP(STEP), .VAL_W(VAL_W), .IDX_W(IDX_W)) table_i (
    .idx   (idx),
    .level (level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_sel  <= SEL_FRAC;
      wr_data <= '0;
    end else begin
      wr_stb <= (act != ACT_NONE);
      unique case (act)
        ACT_FRAC: begin
          wr_sel  <= SEL_FRAC;
          wr_data <= WORD_W'(level) << FRAC_LSB;
        end
        ACT_CLR: begin
          wr_sel  <= SEL_CFG;
          wr_data <= CFG_CLR;
        end
        ACT_SET: begin
          wr_sel  <= SEL_CFG;
          wr_data <= CFG_SET;
        end
        default: begin
          wr_sel  <= SEL_FRAC;
          wr_data <= '0;
        end
      endcase
    end
  end

  // Shadow of the enable bit as seen on the write port, for the checks below
  logic mon_cleared;
  logic mon_frac_seen;
  logic frac_wr, clr_wr, set_wr;

  assign frac_wr = wr_stb && (wr_sel == SEL_FRAC);
  assign clr_wr  = wr_stb && (wr_sel == SEL_CFG) && (wr_data == CFG_CLR);
  assign set_wr  = wr_stb && (wr_sel == SEL_CFG) && (wr_data == CFG_SET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_cleared   <= 1'b0;
      mon_frac_seen <= 1'b0;
    end else begin
      if (clr_wr) mon_cleared <= 1'b1;
      if (set_wr) begin
        mon_cleared   <= 1'b0;
        mon_frac_seen <= 1'b0;
      end
      if (frac_wr) mon_frac_seen <= 1'b1;
    end
  end

  // R5: a fraction word only lands inside a clear/set window, once per window
  assert_frac_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frac_wr |-> (mon_cleared && !mon_frac_seen));

  // R5: while running, the set word follows a fraction word
  assert_set_after_frac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && $past(run_en)) |-> mon_frac_seen);

  // R9: configuration traffic carries only the clear or set word
  assert_cfg_word_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_sel == SEL_CFG) |-> (clr_wr || set_wr));

  // R3: fraction data stays inside its field
  assert_frac_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frac_wr |-> ((wr_data & ~FIELD_MK) == '0));

endmodule

// File: tb/sscg_frac_seq_tb.sv
module sscg_frac_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        trig_in = 1'b0;
  logic        wr_stb;
  logic        wr_sel;
  logic [31:0] wr_data;
  logic        overrun;

  localparam logic [31:0] CLR_W = 32'h0000_0300;
  localparam logic [31:0] SET_W = 32'h0000_0310;

  int n_chk = 0;
  int n_bad = 0;
  int wcount = 0;
  logic        log_sel [0:511];
  logic [31:0] log_dat [0:511];
  int exp_idx = 0;

  always #2 clk = ~clk;

  sscg_frac_seq dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .trig_in(trig_in),
    .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data), .overrun(overrun)
  );

  always @(negedge clk) begin
    if (rst_n && wr_stb && wcount < 512) begin
      log_sel[wcount] = wr_sel;
      log_dat[wcount] = wr_data;
      wcount = wcount + 1;
    end
  end

  // triangle entry, written as a ramp walk rather than a fold
  function automatic logic [31:0] ref_entry(input int k);
    int lvl;
    lvl = 0;
    for (int j = 1; j <= k; j++) lvl = (j <= 16) ? lvl + 32'h200 : lvl - 32'h200;
    if (k == 0) return 32'h0;
    return 32'(lvl - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_wr(input int pos, input logic sel, input logic [31:0] dat, input string req);
    if (pos >= wcount) chk(1'b0, req, 32'(wcount), 32'(pos + 1));
    else chk(log_sel[pos] == sel && log_dat[pos] == dat, req,
             {log_sel[pos], log_dat[pos][30:0]}, {sel, dat[30:0]});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(3);
    chk(wr_stb == 1'b0, "R1 stb in reset", 32'(wr_stb), 0);
    chk(overrun == 1'b0, "R1 overrun in reset", 32'(overrun), 0);
    rst_n = 1'b1;
    cyc(2);
    chk(wr_stb == 1'b0 && wcount == 0, "R1 quiet after reset", 32'(wcount), 0);
  endtask

  // rise first each period: fraction held until the clear (R6), then clr/frac/set
  task automatic t_normal();
    int base;
    base = wcount;
    run_en = 1'b1;
    cyc(4);
    for (int p = 0; p < 40; p++) begin
      trig_in = 1'b1; cyc(8);
      trig_in = 1'b0; cyc(8);
    end
    cyc(10);
    chk(wcount - base == 120, "R4 three writes per period", 32'(wcount - base), 120);
    for (int p = 0; p < 40; p++) begin
      chk_wr(base + 3*p,     1'b1, CLR_W, "R5 clear first");
      chk_wr(base + 3*p + 1, 1'b0, ref_entry(exp_idx) << 3, "R2 R3 fraction entry");
      chk_wr(base + 3*p + 2, 1'b1, SET_W, "R9 set word last");
      exp_idx = (exp_idx + 1) % 32;
    end
    chk(overrun == 1'b0, "R7 no overrun at slow rate", 32'(overrun), 0);
  endtask

  task automatic t_run_gate();
    int base;
    run_en = 1'b0; cyc(4);
    exp_idx = 0;
    run_en = 1'b1; cyc(2);
    base = wcount;
    trig_in = 1'b1; cyc(12);
    chk(wcount == base, "R6 fraction held without clear", 32'(wcount - base), 0);
    trig_in = 1'b0; cyc(12);
    chk(wcount - base == 3, "R6 release after clear", 32'(wcount - base), 3);
    chk_wr(base,     1'b1, CLR_W, "R6 clear");
    chk_wr(base + 1, 1'b0, ref_entry(0), "R8 index back to 0");
    chk_wr(base + 2, 1'b1, SET_W, "R6 set");
    exp_idx = 1;
  endtask

  task automatic t_fall_first();
    int base;
    run_en = 1'b0; cyc(2);
    trig_in = 1'b1; cyc(6);
    base = wcount;
    chk(wcount == base, "R8 edge ignored when stopped", 0, 0);
    run_en = 1'b1; cyc(2);
    trig_in = 1'b0; cyc(12);
    chk(wcount - base == 1, "R5 clear only, set waits", 32'(wcount - base), 1);
    chk_wr(base, 1'b1, CLR_W, "R5 clear issued");
    run_en = 1'b0; cyc(6);
    chk(wcount - base == 2, "R8 stop completes with set", 32'(wcount - base), 2);
    chk_wr(base + 1, 1'b1, SET_W, "R8 enable left set");
    trig_in = 1'b1; cyc(6); trig_in = 1'b0; cyc(6);
    chk(wcount - base == 2, "R8 edges ignored while stopped", 32'(wcount - base), 2);
    exp_idx = 0;
  endtask

  task automatic t_overrun();
    int base;
    run_en = 1'b1; cyc(4);
    base = wcount;
    chk(overrun == 1'b0, "R7 overrun clear before", 32'(overrun), 0);
    trig_in = 1'b1; cyc(1);
    trig_in = 1'b0; cyc(1);
    trig_in = 1'b1; cyc(1);
    trig_in = 1'b0; cyc(14);
    chk(overrun == 1'b1, "R7 overrun raised", 32'(overrun), 1);
    chk(wcount - base == 3, "R7 extra edges dropped", 32'(wcount - base), 3);
    chk_wr(base + 1, 1'b0, ref_entry(exp_idx) << 3, "R4 single fraction");
    trig_in = 1'b1; cyc(8); trig_in = 1'b0; cyc(12);
    chk(overrun == 1'b1, "R7 overrun sticky", 32'(overrun), 1);
    chk_wr(base + 4, 1'b0, ref_entry(exp_idx + 1) << 3, "R4 index advanced by one");
  endtask

  task automatic t_rereset();
    rst_n = 1'b0; cyc(2);
    chk(overrun == 1'b0 && wr_stb == 1'b0, "R1 reset clears flag", 32'(overrun), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_normal();
    t_run_gate();
    t_fall_first();
    t_overrun();
    t_rereset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule